// File: doc/BRIEF.md
# Masked I2C Slave Address Matcher

This block decides whether the local I2C slave is being addressed. A bus shifter hands it each received address byte with a one-cycle valid strobe, together with one-cycle pulses for START and STOP conditions. The block compares those bytes against a configured own address. A per-bit mask turns chosen address bits into don't-cares. The block reports a registered hit flag, the captured read/write direction and a busy indication while a 10-bit address is half received.

Two addressing modes exist. In 7-bit mode a single byte carries the address in its upper seven bits and the direction in bit 0. In 10-bit mode a first byte carries a fixed five-bit prefix, the two top address bits and the direction bit, and a second byte carries the remaining eight bits. After a completed 10-bit match, a repeated START followed by a matching first byte flagged as a read grants the read at once. The mode, address and mask inputs are sampled into shadow copies at each START, so firmware may rewrite them at any time without disturbing a transfer that is in flight.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset all three outputs are 0. The shadow configuration holds address 0, mask all ones and 7-bit mode, and a byte arriving before any START is judged against it: 0x00 or 0x01 hit, and any byte with a 1 in bits 7:1 misses.
- R2: In 7-bit mode, received bits 7:1 are compared with cfg_addr[7:1]. On a hit, rw_bit takes received bit 0 (1 = read). cfg_addr[0] and cfg_mask[0] have no effect in this mode.
- R3: cfg_mask bit n set to 1 requires address bit n to equal cfg_addr bit n, and set to 0 makes it a don't-care. Address bits 9:8 sit in bits 2:1 of the 10-bit first byte. Bits 7:0 sit in the 10-bit second byte, and bits 7:1 in the 7-bit byte.
- R4: In 10-bit mode the first byte misses unless its bits 7:3 are 11110, whatever cfg_addr and cfg_mask hold. Its bits 2:1 are compared with cfg_addr[9:8].
- R5: In 10-bit mode, a matching first byte with bit 0 = 0 raises seq_busy and leaves addr_hit at 0. A matching second byte then raises addr_hit with rw_bit = 0 and drops seq_busy.
- R6: A first byte that misses ends the attempt. No later byte can produce a hit until the next START.
- R7: After a completed 10-bit match, a START with no STOP between, followed by a matching first byte with bit 0 = 1, gives addr_hit = 1 and rw_bit = 1 at once. The same byte after a STOP gives no hit.
- R8: addr_hit and rw_bit change on the clock edge that samples byte_vld and are seen from the next cycle. Once a decision is made, further bytes leave them unchanged.
- R9: A START or STOP pulse clears addr_hit, rw_bit and seq_busy in the following cycle. After a STOP, bytes are ignored until a START.
- R10: Changes to cfg_ten_bit, cfg_addr or cfg_mask take effect only at the next START. A sequence in flight keeps the values captured at its own START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | One-cycle strobe: byte_dat holds a received address byte |
| byte_dat | input | 8 | Received byte, bit 7 first on the wire |
| start_evt | input | 1 | One-cycle pulse on START or repeated START |
| stop_evt | input | 1 | One-cycle pulse on STOP |
| cfg_ten_bit | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| cfg_addr | input | 10 | Own address (7-bit mode uses bits 7:1) |
| cfg_mask | input | 10 | Per-bit compare enable, 1 = compare |
| addr_hit | output | 1 | Slave addressed in the current transfer |
| rw_bit | output | 1 | Captured direction, 1 = read, valid with addr_hit |
| seq_busy | output | 1 | 10-bit first byte matched, second byte pending |

## Verification
The bench builds the block with its default widths: an 8-bit byte and a 10-bit address. These are the only values the bus defines, and with them the fixed 11110 prefix and the split of address bits 9:8 into first-byte bits 2:1 line up as the bus requires. With these widths, random own addresses, masks and near-miss bytes (one bit flipped) reach every per-bit mask path in both modes. Random repeated STARTs and mid-sequence configuration writes reach the read-after-write shortcut and the START-time capture of the configuration.

// File: rtl/i2cam_pkg.sv
// Shared types and constants for the masked I2C address matcher.
// Assumes standard I2C framing: 8-bit bytes and the 10-bit address prefix.
package i2cam_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,  // after STOP: bytes ignored
        PH_FIRST = 2'd1,  // waiting for the first address byte
        PH_LOW   = 2'd2,  // 10-bit: waiting for the second byte
        PH_DONE  = 2'd3   // decision taken, bytes ignored
    } phase_t;

    localparam logic [4:0] TEN_PREFIX = 5'b11110;
endpackage

// File: rtl/i2cam_cfg_shadow.sv
// Holds the configuration used by the current transfer.
// The live inputs are copied at each START. Reset gives 7-bit mode,
// address 0 and a mask of all ones.
module i2cam_cfg_shadow #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              cfg_ten_bit,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_mask,
    output logic              sh_ten_bit,
    output logic [ADDR_W-1:0] sh_addr,
    output logic [ADDR_W-1:0] sh_mask
);
    // Capture the live configuration when a START is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_ten_bit <= 1'b0;
            sh_addr    <= '0;
            sh_mask    <= '1;
        end else if (start_evt) begin
            sh_ten_bit <= cfg_ten_bit;
            sh_addr    <= cfg_addr;
            sh_mask    <= cfg_mask;
        end
    end
endmodule

// File: rtl/i2cam_cmp.sv
// Combinational masked compare of one received byte against the shadow address.
// Gives three verdicts: the 7-bit byte, the 10-bit first byte and the 10-bit
// second byte. Assumes BYTE_W = 8 and ADDR_W = 10, as the bus defines them.
module i2cam_cmp
    import i2cam_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] sh_addr,
    input  logic [ADDR_W-1:0] sh_mask,
    output logic              hit_7b,
    output logic              hit_hi,
    output logic              hit_lo
);
    localparam int HI_W  = ADDR_W - BYTE_W;
    localparam int PFX_W = BYTE_W - HI_W - 1;

    logic [BYTE_W-1:0] miss_lo;
    logic [HI_W-1:0]   miss_hi;

    // A bit misses when it is compared and differs.
    for (genvar n = 0; n < BYTE_W; n++) begin : g_lo
        assign miss_lo[n] = sh_mask[n] & (rx_byte[n] ^ sh_addr[n]);
    end

    // The top address bits sit just above the direction bit of the first byte.
    for (genvar k = 0; k < HI_W; k++) begin : g_hi
        assign miss_hi[k] = sh_mask[BYTE_W+k] & (rx_byte[k+1] ^ sh_addr[BYTE_W+k]);
    end

    // Reduce the per-bit misses to the three verdicts.
    always_comb begin
        hit_7b = ~|miss_lo[BYTE_W-1:1];
        hit_lo = ~|miss_lo;
        hit_hi = (rx_byte[BYTE_W-1 -: PFX_W] == TEN_PREFIX) && ~|miss_hi;
    end
endmodule

// File: rtl/i2cam_seq.sv
// Address phase sequencer. Follows START, STOP and byte strobes, and registers
// the hit and direction one clock after the deciding byte. STOP wins over START,
// and START wins over a byte strobe in the same cycle.
module i2cam_seq
    import i2cam_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic byte_vld,
    input  logic rx_lsb,
    input  logic start_evt,
    input  logic stop_evt,
    input  logic sh_ten_bit,
    input  logic hit_7b,
    input  logic hit_hi,
    input  logic hit_lo,
    output logic addr_hit,
    output logic rw_bit,
    output logic seq_busy
);
    phase_t phase_q;
    logic   ten_done_q;  // a full 10-bit match since the last STOP

    // Advance the address phase and register the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_FIRST;
            addr_hit   <= 1'b0;
            rw_bit     <= 1'b0;
            ten_done_q <= 1'b0;
        end else if (stop_evt) begin
            phase_q    <= PH_IDLE;
            addr_hit   <= 1'b0;
            rw_bit     <= 1'b0;
            ten_done_q <= 1'b0;
        end else if (start_evt) begin
            phase_q  <= PH_FIRST;
            addr_hit <= 1'b0;
            rw_bit   <= 1'b0;
        end else if (byte_vld) begin
            case (phase_q)
                PH_FIRST: begin
                    phase_q <= PH_DONE;
                    if (!sh_ten_bit) begin
                        ten_done_q <= 1'b0;
                        if (hit_7b) begin
                            addr_hit <= 1'b1;
                            rw_bit   <= rx_lsb;
                        end
                    end else if (!hit_hi) begin
                        ten_done_q <= 1'b0;
                    end else if (rx_lsb) begin
                        if (ten_done_q) begin
                            addr_hit <= 1'b1;
                            rw_bit   <= 1'b1;
                        end
                    end else begin
                        ten_done_q <= 1'b0;
                        phase_q    <= PH_LOW;
                    end
                end
                PH_LOW: begin
                    phase_q <= PH_DONE;
                    if (hit_lo) begin
                        addr_hit   <= 1'b1;
                        rw_bit     <= 1'b0;
                        ten_done_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign seq_busy = (phase_q == PH_LOW);

    // R9: a START or STOP clears every output in the next cycle.
    a_r9_events_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt || stop_evt) |=> (!addr_hit && !rw_bit && !seq_busy));
    // R8: a hit holds until a START or STOP.
    a_r8_hit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_hit && !start_evt && !stop_evt) |=> addr_hit);
    // R8: a hit only rises after a byte strobe.
    a_r8_hit_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_hit) |-> $past(byte_vld));
    // R2: a read direction is only reported with a hit.
    a_r2_rw_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rw_bit |-> addr_hit);
    // R5: busy only in 10-bit mode and never together with a hit.
    a_r5_busy_ten_only: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> (sh_ten_bit && !addr_hit));
endmodule

// File: rtl/i2c_addr_match.sv
// Top of the masked I2C slave address matcher. Takes bytes, START and STOP
// pulses from a bus shifter and reports whether this slave is addressed.
// Assumes one-cycle event pulses and standard widths (8-bit byte, 10-bit address).
module i2c_addr_match #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_dat,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              cfg_ten_bit,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_mask,
    output logic              addr_hit,
    output logic              rw_bit,
    output logic              seq_busy
);
    logic              sh_ten_bit;
    logic [ADDR_W-1:0] sh_addr;
    logic [ADDR_W-1:0] sh_mask;
    logic              hit_7b, hit_hi, hit_lo;

    i2cam_cfg_shadow #(.ADDR_W(ADDR_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt),
        .cfg_ten_bit(cfg_ten_bit), .cfg_addr(cfg_addr), .cfg_mask(cfg_mask),
        .sh_ten_bit(sh_ten_bit), .sh_addr(sh_addr), .sh_mask(sh_mask)
    );

    i2cam_cmp #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_cmp (
        .rx_byte(byte_dat), .sh_addr(sh_addr), .sh_mask(sh_mask),
        .hit_7b(hit_7b), .hit_hi(hit_hi), .hit_lo(hit_lo)
    );

    i2cam_seq u_seq (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .rx_lsb(byte_dat[0]),
        .start_evt(start_evt), .stop_evt(stop_evt), .sh_ten_bit(sh_ten_bit),
        .hit_7b(hit_7b), .hit_hi(hit_hi), .hit_lo(hit_lo),
        .addr_hit(addr_hit), .rw_bit(rw_bit), .seq_busy(seq_busy)
    );
endmodule

// File: tb/i2c_addr_match_bench.sv
module i2c_addr_match_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_dat = '0;
    logic       start_evt = 1'b0;
    logic       stop_evt = 1'b0;
    logic       cfg_ten_bit = 1'b0;
    logic [9:0] cfg_addr = '0;
    logic [9:0] cfg_mask = '1;
    logic       addr_hit, rw_bit, seq_busy;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Reference state, built from the requirements
    logic       e_mode, e_hit, e_rw, e_ten;
    logic [9:0] e_addr, e_mask;
    int         e_ph;  // 0 ignore-after-stop, 1 first byte, 2 second byte, 3 decided

    always #5 clk = ~clk;

    i2c_addr_match u_i2c_addr_match (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .start_evt(start_evt), .stop_evt(stop_evt), .cfg_ten_bit(cfg_ten_bit),
        .cfg_addr(cfg_addr), .cfg_mask(cfg_mask),
        .addr_hit(addr_hit), .rw_bit(rw_bit), .seq_busy(seq_busy)
    );

    function automatic bit same(input logic [9:0] got, input logic [9:0] want,
                                input logic [9:0] keep);
        return ((got ^ want) & keep) == 10'd0;
    endfunction

    task automatic ref_reset();
        e_mode = 0; e_addr = '0; e_mask = '1; e_ph = 1;
        e_hit = 0; e_rw = 0; e_ten = 0;
    endtask

    task automatic ref_start();
        e_mode = cfg_ten_bit; e_addr = cfg_addr; e_mask = cfg_mask;
        e_ph = 1; e_hit = 0; e_rw = 0;
    endtask

    task automatic ref_stop();
        e_ph = 0; e_hit = 0; e_rw = 0; e_ten = 0;
    endtask

    task automatic ref_byte(input logic [7:0] b);
        if (e_ph == 1) begin
            e_ph = 3;
            if (!e_mode) begin
                e_ten = 0;
                if (same({2'b00, b[7:1], 1'b0}, {2'b00, e_addr[7:1], 1'b0}, e_mask & 10'h0FE)) begin
                    e_hit = 1; e_rw = b[0];
                end
            end else if (b[7:3] == 5'b11110 &&
                         same({b[2:1], 8'h00}, {e_addr[9:8], 8'h00}, e_mask & 10'h300)) begin
                if (b[0]) begin
                    if (e_ten) begin e_hit = 1; e_rw = 1; end
                end else begin
                    e_ten = 0; e_ph = 2;
                end
            end else begin
                e_ten = 0;
            end
        end else if (e_ph == 2) begin
            e_ph = 3;
            if (same({2'b00, b}, {2'b00, e_addr[7:0]}, e_mask & 10'h0FF)) begin
                e_hit = 1; e_rw = 0; e_ten = 1;
            end
        end
    endtask

    task automatic check(input string tag);
        n_chk++;
        if ({addr_hit, rw_bit, seq_busy} !== {e_hit, e_rw, (e_ph == 2)}) begin
            n_bad++;
            $display("FAIL %s: hit/rw/busy = %b%b%b, expected %b%b%b", tag,
                     addr_hit, rw_bit, seq_busy, e_hit, e_rw, (e_ph == 2));
        end
    endtask

    // Drive one-cycle pulses on the falling edge; outputs are read one cycle later.
    task automatic do_start(input string tag);
        @(negedge clk) start_evt = 1;
        @(negedge clk) start_evt = 0;
        ref_start(); check(tag);
    endtask

    task automatic do_stop(input string tag);
        @(negedge clk) stop_evt = 1;
        @(negedge clk) stop_evt = 0;
        ref_stop(); check(tag);
    endtask

    task automatic do_byte(input logic [7:0] b, input string tag);
        @(negedge clk) begin byte_vld = 1; byte_dat = b; end
        @(negedge clk) byte_vld = 0;
        ref_byte(b); check(tag);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 0;
        @(negedge clk) rst_n = 1;
        ref_reset();
    endtask

    task automatic set_cfg(input logic m, input logic [9:0] a, input logic [9:0] k);
        cfg_ten_bit = m; cfg_addr = a; cfg_mask = k;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            summary();
        end
    end

    initial begin
        logic [7:0] b;
        int unsigned seed;
        seed = $urandom(32'h5EED_1234);
        repeat (2) @(negedge clk);
        do_reset();
        check("R1 reset outputs");
        do_byte(8'h01, "R1 reset shadow hit");
        do_reset();
        do_byte(8'h02, "R1 reset mask all ones");

        // R2: 7-bit compare, direction capture, bit 0 config ignored
        set_cfg(0, 10'h0B5, 10'h3FF);
        do_start("R2 start");
        do_byte(8'hB5, "R2 read hit");
        do_start("R2 restart");
        do_byte(8'hB4, "R2 write hit, cfg bit0 ignored");
        do_byte(8'h00, "R8 data byte leaves hit");
        do_start("R2 restart");
        do_byte(8'hB6, "R2 miss");

        // R3: mask
        set_cfg(0, 10'h0B4, 10'h3F0);
        do_start("R3 start");
        do_byte(8'hB2, "R3 low bits dont care");
        do_start("R3 restart");
        do_byte(8'h34, "R3 compared bit differs");

        // R4, R5: 10-bit
        set_cfg(1, 10'h2C3, 10'h3FF);
        do_start("R4 start");
        do_byte(8'hE4, "R4 bad prefix");
        set_cfg(1, 10'h2C3, 10'h000);
        do_start("R4 start mask zero");
        do_byte(8'h74, "R4 prefix kept with zero mask");
        set_cfg(1, 10'h2C3, 10'h3FF);
        do_start("R5 start");
        do_byte(8'hF4, "R5 first byte busy");
        do_byte(8'hC3, "R5 second byte hit");

        // R7: read after repeated START
        do_start("R7 repeated start");
        do_byte(8'hF5, "R7 read shortcut");
        do_stop("R9 stop clears");
        do_byte(8'hF4, "R9 byte after stop ignored");
        do_start("R7 start after stop");
        do_byte(8'hF5, "R7 no shortcut after stop");

        // R6: first byte mismatch abandons
        do_start("R6 start");
        do_byte(8'hF2, "R6 first byte miss");
        do_byte(8'hC3, "R6 later byte ignored");
        do_byte(8'hF4, "R6 later first byte ignored");

        // R10: config change mid-sequence
        do_start("R10 start");
        do_byte(8'hF4, "R10 first byte");
        set_cfg(0, 10'h000, 10'h3FF);
        do_byte(8'hC3, "R10 old config kept");
        do_start("R10 new config applied");
        do_byte(8'h01, "R10 7-bit after start");

        // R8: timing of the decision
        set_cfg(0, 10'h022, 10'h3FF);
        do_start("R8 start");
        @(negedge clk) begin byte_vld = 1; byte_dat = 8'h22; end
        #1 check("R8 unchanged before edge");
        @(negedge clk) byte_vld = 0;
        ref_byte(8'h22); check("R8 hit after edge");

        // Random transfers with near-miss bytes
        for (int t = 0; t < 400; t++) begin
            logic [9:0] a;
            a = 10'($urandom);
            set_cfg(1'($urandom), a, ($urandom % 2) ? 10'h3FF : 10'($urandom));
            do_start("random start");
            if (cfg_ten_bit) b = {5'b11110, a[9:8], 1'b0};
            else             b = {a[7:1], 1'($urandom)};
            if ($urandom % 4 == 0) b[$urandom % 8] ^= 1'b1;
            do_byte(b, "random first byte");
            if ($urandom % 3 == 0) set_cfg(1'($urandom), 10'($urandom), 10'($urandom));
            b = a[7:0];
            if ($urandom % 4 == 0) b[$urandom % 8] ^= 1'b1;
            do_byte(b, "random second byte");
            if ($urandom % 2 == 0) begin
                do_start("random repeated start");
                do_byte({5'b11110, a[9:8], 1'b1}, "random read first byte");
            end
            if ($urandom % 10 < 7) do_stop("random stop");
        end

        finished = 1'b1;
        summary();
    end
endmodule